// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block turns an asynchronous serial line into bytes. The line is idle high. Each frame opens with a low start bit, carries eight data bits with the least significant bit first, may carry one parity bit, and closes with a high stop bit. The receiver runs on the system clock. It looks at the line only when `sample_tick` pulses, and that pulse is supplied at sixteen times the bit rate. Before any logic uses the line, a chain of flip-flops resynchronises it. The block looks for a high-to-low transition and checks the line again half a bit later to confirm the start bit. From that confirmed midpoint it samples every following bit one full bit period apart.

Each completed byte is placed in a one-entry holding register. The register carries the byte's parity and framing flags and is offered on a valid/ready output. `out_valid` stays high until the consumer takes the byte by asserting `out_ready` in the same cycle. The consumer may hold `out_ready` low for as long as it likes. While it does, the held byte and its flags stay frozen. If another frame completes during that time, the new byte is discarded and `out_overrun` is raised. `out_overrun` clears when the held byte is accepted.

Top module: `serial_rx_core`

## Requirements
- R1: After reset `out_valid` and `out_overrun` are low, and a line held high never produces a byte.
- R2: A start is confirmed only if the line is still low eight sample ticks after the falling edge was seen. A low pulse that has ended by then is discarded and produces no byte.
- R3: Eight data bits are assembled least significant bit first. Each bit is sampled sixteen ticks after the previous sample, starting from the confirmed start midpoint.
- R4: The `parity_mode` encoding is 2'b00 for no parity bit, 2'b01 for even parity, 2'b10 for odd parity, and 2'b11 for no parity bit. The mode is captured when a start edge is seen.
- R5: `out_par_err` is high when the count of ones in the data plus the parity bit is odd in even mode, or even in odd mode. It is always low when no parity bit is used.
- R6: A stop bit sampled low sets `out_frm_err` for that byte, and the byte is still delivered.
- R7: `out_valid` rises within a few clocks of the stop-bit sample. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and both error flags hold their values.
- R8: When `out_valid` and `out_ready` are both high in a cycle, `out_valid` is low in the next cycle, unless a new byte completes in that same cycle.
- R9: A byte that completes while `out_valid` is high and `out_ready` is low is dropped. The held byte is kept unchanged, `out_overrun` goes high, and it returns low when the held byte is accepted.
- R10: After a frame with a framing error, once the line has returned high, the next frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| sample_tick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| parity_mode | input | 2 | 00 none, 01 even, 10 odd, 11 none |
| out_valid | output | 1 | Holding register contains a byte |
| out_ready | input | 1 | Consumer takes the byte when high together with out_valid |
| out_data | output | 8 | Received byte |
| out_par_err | output | 1 | Parity mismatch for the held byte |
| out_frm_err | output | 1 | Stop bit of the held byte was low |
| out_overrun | output | 1 | A later byte was dropped while this byte was held |

## Verification
The bench sends the bytes 0x01 and 0x80, whose single set bit sits at opposite ends, so any reversal of bit order or shift by one position is exposed. It uses a byte with an odd number of ones in even and odd modes, each with a correct and an inverted parity bit, and repeats one frame with mode 2'b11. This separates the two parity senses from each other and from the no-parity framing. It also sends a short low glitch, a frame with a low stop bit followed by a clean frame, and two frames without a read in between. These cases tell start validation, framing recovery and overrun handling apart from ordinary reception.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  typedef enum logic [1:0] {
    PAR_NONE     = 2'b00,
    PAR_EVEN     = 2'b01,
    PAR_ODD      = 2'b10,
    PAR_NONE_ALT = 2'b11
  } par_mode_t;

  function automatic logic par_used(input logic [1:0] m);
    return (m == PAR_EVEN) || (m == PAR_ODD);
  endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OSR       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line,
  input  logic                 tick,
  input  logic [1:0]           mode,
  output logic                 done,
  output logic [DATA_BITS-1:0] done_data,
  output logic                 done_perr,
  output logic                 done_ferr
);
  localparam int CW   = $clog2(OSR);
  localparam int IW   = $clog2(DATA_BITS + 1);
  localparam int HALF = OSR / 2;

  rx_state_t             st;
  logic [CW-1:0]         tcnt;
  logic [IW-1:0]         bidx;
  logic                  prev;
  logic [1:0]            mode_q;
  logic                  pbit;
  logic [DATA_BITS-1:0]  shreg;
  logic                  full_bit;
  logic                  ones_odd;

  assign full_bit = (tcnt == CW'(OSR - 1));
  assign ones_odd = (^shreg) ^ pbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      prev      <= 1'b1;
      mode_q    <= PAR_NONE;
      pbit      <= 1'b0;
      shreg     <= '0;
      done      <= 1'b0;
      done_data <= '0;
      done_perr <= 1'b0;
      done_ferr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        prev <= line;
        unique case (st)
          ST_IDLE: begin
            if (prev && !line) begin
              st     <= ST_START;
              tcnt   <= '0;
              mode_q <= mode;
              pbit   <= 1'b0;
            end
          end
          ST_START: begin
            if (tcnt == CW'(HALF - 1)) begin
              tcnt <= '0;
              bidx <= '0;
              st   <= line ? ST_IDLE : ST_DATA;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (full_bit) begin
              tcnt  <= '0;
              shreg <= {line, shreg[DATA_BITS-1:1]};
              if (bidx == IW'(DATA_BITS - 1))
                st <= par_used(mode_q) ? ST_PAR : ST_STOP;
              else
                bidx <= bidx + 1'b1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (full_bit) begin
              tcnt <= '0;
              pbit <= line;
              st   <= ST_STOP;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (full_bit) begin
              tcnt      <= '0;
              st        <= ST_IDLE;
              done      <= 1'b1;
              done_data <= shreg;
              done_ferr <= !line;
              unique case (mode_q)
                PAR_EVEN: done_perr <= ones_odd;
                PAR_ODD:  done_perr <= !ones_odd;
                default:  done_perr <= 1'b0;
              endcase
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_done,
  input  logic [DATA_BITS-1:0] in_data,
  input  logic                 in_perr,
  input  logic                 in_ferr,
  output logic                 valid,
  input  logic                 ready,
  output logic [DATA_BITS-1:0] data,
  output logic                 perr,
  output logic                 ferr,
  output logic                 overrun
);
  logic accept;
  logic blocked;

  assign accept  = valid && ready;
  assign blocked = valid && !ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      data    <= '0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
      overrun <= 1'b0;
    end else if (in_done) begin
      if (blocked) begin
        overrun <= 1'b1;
      end else begin
        valid   <= 1'b1;
        data    <= in_data;
        perr    <= in_perr;
        ferr    <= in_ferr;
        overrun <= 1'b0;
      end
    end else if (accept) begin
      valid   <= 1'b0;
      overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int DATA_BITS   = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd,
  input  logic                 sample_tick,
  input  logic [1:0]           parity_mode,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DATA_BITS-1:0] out_data,
  output logic                 out_par_err,
  output logic                 out_frm_err,
  output logic                 out_overrun
);
  logic                 line_s;
  logic                 frm_done;
  logic [DATA_BITS-1:0] frm_data;
  logic                 frm_perr;
  logic                 frm_ferr;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (rxd),
    .q_sync  (line_s)
  );

  serial_rx_frame #(.DATA_BITS(DATA_BITS), .OSR(OSR)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .line      (line_s),
    .tick      (sample_tick),
    .mode      (parity_mode),
    .done      (frm_done),
    .done_data (frm_data),
    .done_perr (frm_perr),
    .done_ferr (frm_ferr)
  );

  serial_rx_hold #(.DATA_BITS(DATA_BITS)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_done (frm_done),
    .in_data (frm_data),
    .in_perr (frm_perr),
    .in_ferr (frm_ferr),
    .valid   (out_valid),
    .ready   (out_ready),
    .data    (out_data),
    .perr    (out_par_err),
    .ferr    (out_frm_err),
    .overrun (out_overrun)
  );
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           parity_mode,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [DATA_BITS-1:0] out_data,
  input logic                 out_par_err,
  input logic                 out_frm_err,
  input logic                 out_overrun,
  input logic                 frm_done,
  input logic                 frm_perr
);
  logic [1:0] mode_at_start;
  logic       seen_edge_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_at_start  <= 2'b00;
      seen_edge_mode <= 1'b0;
    end else begin
      seen_edge_mode <= 1'b1;
      mode_at_start  <= parity_mode;
    end
  end

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
                                && $stable(out_par_err) && $stable(out_frm_err));

  assert_valid_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(frm_done));

  assert_accept_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !frm_done |=> !out_valid);

  assert_overrun_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && frm_done |=> out_overrun && $stable(out_data));

  assert_overrun_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_overrun);

  assert_overrun_needs_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_overrun |-> out_valid);

  assert_no_perr_idle_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && seen_edge_mode && (mode_at_start == 2'b00) && $stable(parity_mode)
      && (parity_mode == 2'b00) |-> !frm_perr);
endmodule

bind serial_rx_core serial_rx_checker #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .parity_mode (parity_mode),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_par_err (out_par_err),
  .out_frm_err (out_frm_err),
  .out_overrun (out_overrun),
  .frm_done    (frm_done),
  .frm_perr    (frm_perr)
);

// File: tb/serial_rx_core_bench.sv
`timescale 1ns/1ps
module serial_rx_core_bench;
  localparam int DIV      = 4;
  localparam int OSR      = 16;
  localparam int BIT_CLKS = DIV * OSR;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       sample_tick;
  logic [1:0] parity_mode = 2'b00;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       out_par_err;
  logic       out_frm_err;
  logic       out_overrun;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;
  int dcnt;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) dcnt <= 0;
    else        dcnt <= (dcnt == DIV - 1) ? 0 : dcnt + 1;
  end
  assign sample_tick = rst_n && (dcnt == DIV - 1);

  serial_rx_core u_serial_rx_core (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .sample_tick(sample_tick),
    .parity_mode(parity_mode), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_par_err(out_par_err), .out_frm_err(out_frm_err),
    .out_overrun(out_overrun)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int clks);
    rxd = v;
    repeat (clks) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [1:0] m,
                            input logic bad_par, input logic stop_v);
    logic p;
    parity_mode = m;
    hold_line(1'b0, BIT_CLKS);
    for (int i = 0; i < 8; i++) hold_line(d[i], BIT_CLKS);
    if (m == 2'b01 || m == 2'b10) begin
      p = (m == 2'b01) ? ^d : ~^d;
      hold_line(p ^ bad_par, BIT_CLKS);
    end
    hold_line(stop_v, BIT_CLKS);
    hold_line(1'b1, BIT_CLKS);
  endtask

  task automatic take_byte();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic expect_byte(input string req, input logic [7:0] d,
                             input logic pe, input logic fe);
    check({req, " valid"}, out_valid, 1);
    check({req, " data"}, out_data, d);
    check({req, " par_err"}, out_par_err, pe);
    check({req, " frm_err"}, out_frm_err, fe);
  endtask

  task automatic t_reset();
    hold_line(1'b1, 2 * BIT_CLKS);
    check("R1 valid after reset", out_valid, 0);
    check("R1 overrun after reset", out_overrun, 0);
  endtask

  task automatic t_basic();
    send_frame(8'hA5, 2'b00, 1'b0, 1'b1);
    expect_byte("R3 R7 byte A5", 8'hA5, 0, 0);
    take_byte();
    check("R8 valid after accept", out_valid, 0);
  endtask

  task automatic t_order();
    send_frame(8'h01, 2'b00, 1'b0, 1'b1);
    expect_byte("R3 lsb first 01", 8'h01, 0, 0);
    take_byte();
    send_frame(8'h80, 2'b00, 1'b0, 1'b1);
    expect_byte("R3 msb last 80", 8'h80, 0, 0);
    take_byte();
  endtask

  task automatic t_parity();
    send_frame(8'h37, 2'b01, 1'b0, 1'b1);
    expect_byte("R5 even good", 8'h37, 0, 0);
    take_byte();
    send_frame(8'h37, 2'b01, 1'b1, 1'b1);
    expect_byte("R5 even bad", 8'h37, 1, 0);
    take_byte();
    send_frame(8'h37, 2'b10, 1'b0, 1'b1);
    expect_byte("R5 odd good", 8'h37, 0, 0);
    take_byte();
    send_frame(8'h37, 2'b10, 1'b1, 1'b1);
    expect_byte("R5 odd bad", 8'h37, 1, 0);
    take_byte();
    send_frame(8'h5A, 2'b11, 1'b0, 1'b1);
    expect_byte("R4 mode 11 no parity bit", 8'h5A, 0, 0);
    take_byte();
    parity_mode = 2'b00;
  endtask

  task automatic t_framing();
    send_frame(8'hC3, 2'b00, 1'b0, 1'b0);
    expect_byte("R6 low stop", 8'hC3, 0, 1);
    take_byte();
    send_frame(8'h3C, 2'b00, 1'b0, 1'b1);
    expect_byte("R10 after framing error", 8'h3C, 0, 0);
    take_byte();
  endtask

  task automatic t_glitch();
    hold_line(1'b0, 3 * DIV);
    hold_line(1'b1, 12 * BIT_CLKS);
    check("R2 glitch gives no byte", out_valid, 0);
    send_frame(8'h99, 2'b00, 1'b0, 1'b1);
    expect_byte("R2 frame after glitch", 8'h99, 0, 0);
    take_byte();
  endtask

  task automatic t_overrun();
    send_frame(8'h11, 2'b00, 1'b0, 1'b1);
    hold_line(1'b1, 3 * BIT_CLKS);
    expect_byte("R7 held while not ready", 8'h11, 0, 0);
    check("R9 no overrun yet", out_overrun, 0);
    send_frame(8'h22, 2'b00, 1'b0, 1'b1);
    expect_byte("R9 older byte kept", 8'h11, 0, 0);
    check("R9 overrun set", out_overrun, 1);
    take_byte();
    check("R9 valid after accept", out_valid, 0);
    check("R9 overrun cleared", out_overrun, 0);
    send_frame(8'h33, 2'b00, 1'b0, 1'b1);
    expect_byte("R9 next byte after overrun", 8'h33, 0, 0);
    take_byte();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_order();
    t_parity();
    t_framing();
    t_glitch();
    t_overrun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule